// File: doc/BRIEF.md
# Byte ALU with Carry, Half-Carry and Zero Flags

This block is the arithmetic core of a small 8-bit controller datapath. Each cycle it takes two operand bytes and a 4-bit operation code. It returns the result byte combinationally, in the same cycle. It also keeps three registered status bits: carry, nibble (half) carry and zero. The current carry bit feeds back into the rotate operations, which treat it as a ninth bit of the byte. Subtraction is done by adding the inverted subtrahend plus one. As a result, both carry bits read 1 when no borrow occurs and 0 when one does.

The flag register loads only on a rising clock edge with the flag write enable high. An instruction sequencer sets the operation code and the enable, and routes the result wherever it needs to go. The operand width and the nibble split point are parameters. A parameter also picks one of two adder implementations.

Top module: `byte_alu_flags`

## Requirements
- R1: Code 0 (add) gives result = (A+B) mod 256. C becomes the carry out of bit 7. The incoming C is not added.
- R2: Code 1 (subtract) gives result = (A−B) mod 256. C becomes 1 when A ≥ B (unsigned, no borrow) and 0 when A < B.
- R3: DC becomes the carry out of bit 3 of the adder. For add, that is a carry out of the low nibble. For subtract, DC is 1 when A[3:0] ≥ B[3:0] and 0 when the low nibble borrows.
- R4: Code 8 rotates right through C: result = {C, A[7:1]} and the new C = A[0]. Code 9 rotates left through C: result = {A[6:0], C} and the new C = A[7]. Nine successive rotates in one direction, each fed its own previous result, restore both the byte and C. DC is left unchanged.
- R5: Codes 2 (AND), 3 (OR) and 4 (XOR) combine A with B. Code 5 gives the bitwise complement of A. These four leave C and DC unchanged.
- R6: Code 6 gives A+1 and code 7 gives A−1, both mod 256. Only Z may change. C and DC are unchanged even when the value wraps.
- R7: Z becomes 1 when the result is zero for codes 0 to 7. The rotates (codes 8 and 9) leave Z unchanged, even when their result is zero.
- R8: Reset (rst_n low, asynchronous) clears C, DC and Z to 0. With flag_we low, a rising edge leaves all three flags unchanged, whatever the operation.
- R9: Codes 10 to 15 are reserved. The result equals A and no flag changes.
- R10: The result depends combinationally on the present operands, code and C. It is valid in the same cycle, before the flag update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the flags load on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the flags |
| op_sel | input | 4 | Operation code (see R1 to R9) |
| opd_a | input | 8 | First operand byte |
| opd_b | input | 8 | Second operand byte |
| flag_we | input | 1 | Flag write enable |
| result | output | 8 | Combinational result byte |
| flag_c | output | 1 | Registered carry / not-borrow |
| flag_dc | output | 1 | Registered nibble carry / not-borrow |
| flag_z | output | 1 | Registered zero flag |

## Verification
The add and subtract vectors are chosen to separate full-byte carry from nibble carry. They pair a low-nibble carry with no byte carry, a byte carry with no nibble carry, equal operands, and a nibble borrow without a byte borrow. Each vector first loads one of three distinct flag states, C/DC/Z = 0/0/0, 1/0/1 or 1/1/0. A flag that must stay untouched is therefore seen to hold both a 0 and a 1. The rotates are tried with C at 0 and at 1, and with a zero result under a Z that was 0, which shows that Z stays unchanged. A nine-step chain in each direction confirms the ninth-bit behaviour. Separate directed steps cover reset, a disabled write and a reserved code.

// File: rtl/bau_pkg.sv
package bau_pkg;
   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_SUB = 4'd1,
      OP_AND = 4'd2,
      OP_OR  = 4'd3,
      OP_XOR = 4'd4,
      OP_NOT = 4'd5,
      OP_INC = 4'd6,
      OP_DEC = 4'd7,
      OP_RR  = 4'd8,
      OP_RL  = 4'd9
   } bau_op_e;

   localparam int unsigned BAU_OP_W = 4;
   localparam int unsigned BAU_NFLAGS = 3;
endpackage

// File: rtl/bau_addsub.sv
// Adder/subtractor exposing carry out of the nibble split point and of the MSB.
module bau_addsub #(
   parameter int unsigned W     = 8,
   parameter int unsigned NIB   = 4,
   parameter int unsigned STYLE = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         nib_co,
   output logic         msb_co
);
   localparam int unsigned HI_W = W - NIB;

   initial begin
      assert (NIB > 0 && NIB < W) else $error("bau_addsub: NIB must lie inside the word");
      assert (STYLE <= 1) else $error("bau_addsub: STYLE must be 0 or 1");
   end

   logic [W-1:0] b_eff;
   assign b_eff = sub ? ~b : b;

   generate
      if (STYLE == 0) begin : g_split
         // Two short adders joined at the nibble boundary.
         logic [NIB:0]  lo;
         logic [HI_W:0] hi;
         always_comb begin
            lo = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub};
            hi = {1'b0, a[W-1:NIB]} + {1'b0, b_eff[W-1:NIB]} + {{HI_W{1'b0}}, lo[NIB]};
         end
         assign sum    = {hi[HI_W-1:0], lo[NIB-1:0]};
         assign nib_co = lo[NIB];
         assign msb_co = hi[HI_W];
      end else begin : g_ripple
         // Bitwise ripple chain; nibble carry tapped mid-chain.
         logic [W:0] cy;
         assign cy[0] = sub;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]  = a[i] ^ b_eff[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b_eff[i]) | (cy[i] & (a[i] ^ b_eff[i]));
         end
         assign nib_co = cy[NIB];
         assign msb_co = cy[W];
      end
   endgenerate
endmodule

// File: rtl/bau_logic.sv
// Bitwise operations; complement acts on the first operand only.
module bau_logic
   import bau_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  bau_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   always_comb begin
      case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         OP_NOT:  y = ~a;
         default: y = a;
      endcase
   end
endmodule

// File: rtl/bau_rotate.sv
// Rotate through a carry bit that acts as bit W of a (W+1)-bit ring.
module bau_rotate #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0] din,
   input  logic         cin,
   input  logic         left,
   output logic [W-1:0] dout,
   output logic         cout
);
   initial begin
      assert (W >= 2) else $error("bau_rotate: width below 2");
   end

   always_comb begin
      if (left) begin
         dout = {din[W-2:0], cin};
         cout = din[W-1];
      end else begin
         dout = {cin, din[W-1:1]};
         cout = din[0];
      end
   end
endmodule

// File: rtl/bau_flagreg.sv
// Status bits with asynchronous clear and synchronous load enable.
module bau_flagreg #(
   parameter int unsigned N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
endmodule

// File: rtl/byte_alu_flags.sv
module byte_alu_flags
   import bau_pkg::*;
#(
   parameter int unsigned WIDTH       = 8,
   parameter int unsigned NIBBLE      = 4,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] opd_a,
   input  logic [WIDTH-1:0] opd_b,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic             flag_c,
   output logic             flag_dc,
   output logic             flag_z
);
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   initial begin
      assert (WIDTH >= 2 * NIBBLE) else $error("byte_alu_flags: WIDTH too small for nibble split");
      assert ($bits(op_sel) == BAU_OP_W) else $error("byte_alu_flags: op width mismatch");
   end

   bau_op_e op;
   assign op = bau_op_e'(op_sel);

   // One shared adder serves add, subtract, increment and decrement.
   logic             is_incdec;
   logic [WIDTH-1:0] as_b;
   logic             as_sub;
   logic [WIDTH-1:0] as_sum;
   logic             as_nib_co, as_msb_co;

   assign is_incdec = (op == OP_INC) || (op == OP_DEC);
   assign as_b      = is_incdec ? ONE : opd_b;
   assign as_sub    = (op == OP_SUB) || (op == OP_DEC);

   bau_addsub #(.W(WIDTH), .NIB(NIBBLE), .STYLE(ADDER_STYLE)) u_addsub (
      .a(opd_a), .b(as_b), .sub(as_sub),
      .sum(as_sum), .nib_co(as_nib_co), .msb_co(as_msb_co)
   );

   logic [WIDTH-1:0] lg_y;
   bau_logic #(.W(WIDTH)) u_logic (.op(op), .a(opd_a), .b(opd_b), .y(lg_y));

   logic [WIDTH-1:0] rt_y;
   logic             rt_co;
   bau_rotate #(.W(WIDTH)) u_rotate (
      .din(opd_a), .cin(flag_c), .left(op == OP_RL), .dout(rt_y), .cout(rt_co)
   );

   logic c_nx, dc_nx, z_nx;
   always_comb begin
      result = opd_a;
      c_nx   = flag_c;
      dc_nx  = flag_dc;
      z_nx   = flag_z;
      case (op)
         OP_ADD, OP_SUB: begin
            result = as_sum;
            c_nx   = as_msb_co;
            dc_nx  = as_nib_co;
            z_nx   = (as_sum == '0);
         end
         OP_AND, OP_OR, OP_XOR, OP_NOT: begin
            result = lg_y;
            z_nx   = (lg_y == '0);
         end
         OP_INC, OP_DEC: begin
            result = as_sum;
            z_nx   = (as_sum == '0);
         end
         OP_RR, OP_RL: begin
            result = rt_y;
            c_nx   = rt_co;
         end
         default: ;
      endcase
   end

   logic [BAU_NFLAGS-1:0] fl_q;
   bau_flagreg #(.N(BAU_NFLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .we(flag_we),
      .d({c_nx, dc_nx, z_nx}), .q(fl_q)
   );
   assign {flag_c, flag_dc, flag_z} = fl_q;

   // Reference quantities for the checks below, formed from the ports.
   logic [WIDTH:0] ref_wide_add;
   assign ref_wide_add = {1'b0, opd_a} + {1'b0, opd_b};
   logic is_logic_op, is_rot_op, is_rsvd_op;
   assign is_logic_op = (op_sel >= 4'd2) && (op_sel <= 4'd5);
   assign is_rot_op   = (op_sel == 4'd8) || (op_sel == 4'd9);
   assign is_rsvd_op  = (op_sel >= 4'd10);

   p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 4'd0) |=> flag_c == $past(ref_wide_add[WIDTH]));
   p_sub_noborrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 4'd1) |=> flag_c == ($past(opd_a) >= $past(opd_b)));
   p_sub_nibble_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 4'd1) |=>
         flag_dc == ($past(opd_a[NIBBLE-1:0]) >= $past(opd_b[NIBBLE-1:0])));
   p_rr_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 4'd8) |=> flag_c == $past(opd_a[0]));
   p_rl_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == 4'd9) |=> flag_c == $past(opd_a[WIDTH-1]));
   p_logic_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && is_logic_op) |=> $stable(flag_c) && $stable(flag_dc));
   p_incdec_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && (op_sel == 4'd6 || op_sel == 4'd7)) |=> $stable(flag_c) && $stable(flag_dc));
   p_rot_zkeep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && is_rot_op) |=> $stable(flag_z) && $stable(flag_dc));
   p_rsvd_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && is_rsvd_op) |=> $stable(flag_c) && $stable(flag_dc) && $stable(flag_z));
endmodule

// File: tb/sim_byte_alu_flags.sv
`timescale 1ns/1ps
module sim_byte_alu_flags;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_sel = 4'd0;
   logic [7:0] opd_a = 8'h00, opd_b = 8'h00;
   logic       flag_we = 1'b0;
   logic [7:0] result;
   logic       flag_c, flag_dc, flag_z;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   byte_alu_flags u0 (
      .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opd_a(opd_a), .opd_b(opd_b),
      .flag_we(flag_we), .result(result), .flag_c(flag_c), .flag_dc(flag_dc), .flag_z(flag_z)
   );

   // {preset[1:0], op[3:0], a, b, expected result, expected C/DC/Z}
   // preset 0 -> C/DC/Z = 000, 1 -> 101, 2 -> 110
   localparam int NV = 20;
   localparam logic [32:0] VEC [NV] = '{
      {2'd0, 4'd0, 8'h3A, 8'h47, 8'h81, 3'b010},
      {2'd0, 4'd0, 8'hF0, 8'h10, 8'h00, 3'b101},
      {2'd1, 4'd0, 8'h0F, 8'h01, 8'h10, 3'b010},
      {2'd0, 4'd1, 8'h50, 8'h20, 8'h30, 3'b110},
      {2'd1, 4'd1, 8'h20, 8'h21, 8'hFF, 3'b000},
      {2'd0, 4'd1, 8'h34, 8'h34, 8'h00, 3'b111},
      {2'd0, 4'd1, 8'h13, 8'h05, 8'h0E, 3'b100},
      {2'd1, 4'd2, 8'hF0, 8'h0F, 8'h00, 3'b101},
      {2'd2, 4'd3, 8'hA0, 8'h05, 8'hA5, 3'b110},
      {2'd1, 4'd4, 8'hFF, 8'hFF, 8'h00, 3'b101},
      {2'd0, 4'd5, 8'h5A, 8'h00, 8'hA5, 3'b000},
      {2'd1, 4'd6, 8'hFF, 8'h00, 8'h00, 3'b101},
      {2'd0, 4'd7, 8'h00, 8'h00, 8'hFF, 3'b000},
      {2'd1, 4'd7, 8'h01, 8'h00, 8'h00, 3'b101},
      {2'd2, 4'd8, 8'h02, 8'h00, 8'h81, 3'b010},
      {2'd0, 4'd8, 8'h01, 8'h00, 8'h00, 3'b100},
      {2'd1, 4'd9, 8'h40, 8'h00, 8'h81, 3'b001},
      {2'd0, 4'd9, 8'h80, 8'h00, 8'h00, 3'b100},
      {2'd0, 4'd12, 8'h00, 8'h12, 8'h00, 3'b000},
      {2'd2, 4'd15, 8'h9C, 8'h00, 8'h9C, 3'b110}
   };

   function automatic string op_tag(input logic [3:0] op);
      case (op)
         4'd0: return "R1";
         4'd1: return "R2";
         4'd2, 4'd3, 4'd4, 4'd5: return "R5";
         4'd6, 4'd7: return "R6";
         4'd8, 4'd9: return "R4";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b, input logic we);
      @(negedge clk);
      op_sel = op; opd_a = a; opd_b = b; flag_we = we;
   endtask

   task automatic preset(input logic [1:0] p);
      case (p)
         2'd0: apply(4'd0, 8'h01, 8'h01, 1'b1);
         2'd1: apply(4'd0, 8'h80, 8'h80, 1'b1);
         default: apply(4'd0, 8'h88, 8'h88, 1'b1);
      endcase
      @(posedge clk); #1;
   endtask

   initial begin
      #800000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R8: reset state
      repeat (3) @(posedge clk);
      #1;
      check("R8", "flags in reset", {5'd0, flag_c, flag_dc, flag_z}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      // Table walk
      for (int i = 0; i < NV; i++) begin
         logic [1:0] pr;
         logic [3:0] op;
         logic [7:0] a, b, er;
         logic [2:0] ef;
         {pr, op, a, b, er, ef} = VEC[i];
         preset(pr);
         apply(op, a, b, 1'b1);
         #1;
         check(op_tag(op), "result", result, er);
         @(posedge clk); #1;
         check(op_tag(op), "C", {7'd0, flag_c}, {7'd0, ef[2]});
         check((op <= 4'd1) ? "R3" : op_tag(op), "DC", {7'd0, flag_dc}, {7'd0, ef[1]});
         check("R7", "Z", {7'd0, flag_z}, {7'd0, ef[0]});
      end

      // R8: disabled write holds flags (preset 2 = 110) despite subtract with borrow
      preset(2'd2);
      apply(4'd1, 8'h00, 8'h01, 1'b0);
      #1;
      check("R2", "result with we low", result, 8'hFF);
      @(posedge clk); #1;
      check("R8", "flags held with we low", {5'd0, flag_c, flag_dc, flag_z}, 8'h06);

      // R10: result follows C in the same cycle (C=1 from preset 1)
      preset(2'd1);
      apply(4'd8, 8'h00, 8'h00, 1'b0);
      #1;
      check("R10", "rotate result before edge", result, 8'h80);

      // R4: nine rotates right restore byte and C (start C=1, byte B4)
      preset(2'd1);
      begin
         logic [7:0] v;
         v = 8'hB4;
         for (int k = 0; k < 9; k++) begin
            apply(4'd8, v, 8'h00, 1'b1);
            #1; v = result;
            @(posedge clk); #1;
         end
         check("R4", "byte after nine right rotates", v, 8'hB4);
         check("R4", "C after nine right rotates", {7'd0, flag_c}, 8'h01);
      end

      // R4: nine rotates left restore byte and C (start C=0, byte 6D)
      preset(2'd0);
      begin
         logic [7:0] v;
         v = 8'h6D;
         for (int k = 0; k < 9; k++) begin
            apply(4'd9, v, 8'h00, 1'b1);
            #1; v = result;
            @(posedge clk); #1;
         end
         check("R4", "byte after nine left rotates", v, 8'h6D);
         check("R4", "C after nine left rotates", {7'd0, flag_c}, 8'h00);
      end

      // R8: asynchronous reset mid-run clears flags
      preset(2'd2);
      @(negedge clk); flag_we = 1'b0; rst_n = 1'b0;
      #1;
      check("R8", "flags after async reset", {5'd0, flag_c, flag_dc, flag_z}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule